// File: doc/BRIEF.md
# Converter Result Holding Registers

This block sits between a 10-bit conversion engine and an 8-bit processor register bus. Each time the engine finishes a conversion it pulses a done strobe along with the raw result. The block stores the raw value unformatted and presents it as a high byte and a low byte. A configuration bit chooses whether the value is packed toward the bottom (right-aligned) or toward the top (left-aligned).

Software that needs all ten bits reads the low byte first and the high byte second. The low-byte read freezes the stored value, so the two bytes always come from the same conversion. The high-byte read releases the freeze. Software that only needs eight bits can set left alignment and read just the high byte, which never freezes anything.

Every completion raises a flag. Software clears the flag by writing a one to it. The flag drives an interrupt line when the enable bit is set.

Top module: `adc_result_regs`

## Requirements
- R1: A synchronous active-high reset clears the stored result, the freeze, the flag, the interrupt enable and the alignment bit. After reset all three registers read zero.
- R2: Register map. Address 0 is the low byte, address 1 the high byte and address 2 the control byte, laid out as bit 0 alignment (1 = left), bit 1 interrupt enable and bit 2 flag. Read data is a combinational function of the address. Address 3 reads zero.
- R3: With alignment 0, the low byte is result[7:0] and the high byte is {6'b0, result[9:8]}.
- R4: With alignment 1, the high byte is result[9:2] and the low byte is {result[1:0], 6'b0}.
- R5: A read strobe at address 0 freezes the stored result from the next cycle on. A done strobe that arrives while frozen, or in the same cycle as a low-byte read, is dropped, and the old value stays.
- R6: A read strobe at address 1 ends the freeze on that clock edge, so a done strobe on the next cycle is captured. A high-byte read on its own never freezes the registers.
- R7: Every done strobe sets the flag, including one whose value is dropped. The interrupt output equals flag AND enable.
- R8: A write to address 2 with bit 2 set clears the flag. A done strobe in the same cycle wins, and the flag stays set.
- R9: A write to address 2 loads alignment and enable from bits 0 and 1. A new alignment reformats the stored value at once, with no new conversion.
- R10: A done strobe while not frozen stores conv_data_i, and the new value is readable in the cycle after the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| conv_done_i | input | 1 | One-cycle strobe marking a finished conversion |
| conv_data_i | input | RES_W | Raw conversion value, valid with the strobe |
| bus_addr_i | input | 2 | Register address |
| bus_rd_i | input | 1 | Read strobe; its side effects happen at the clock edge |
| bus_wr_i | input | 1 | Write strobe |
| bus_wdata_i | input | BUS_W | Write data |
| bus_rdata_o | output | BUS_W | Read data for bus_addr_i, combinational |
| irq_o | output | 1 | Conversion-complete interrupt |

## Verification
Read data is combinational, so the bench compares it against the model in the same cycle as the address, before the edge. Strobes, writes and reads take effect on the next rising edge. A captured value, a freeze, a release, a flag change or an interrupt change therefore appears exactly one cycle after its stimulus, and the bench checks it at the following falling edge. Between steps, the bench scans every address with the read strobe low, which exposes the stored state without disturbing it. The model is updated once per edge from the inputs driven for that edge, so cases where two things happen in the same cycle (done with a clear, done with a low read, done with a high read) come out of the model's own ordering.

// File: rtl/adc_rr_pkg.sv
package adc_rr_pkg;
    localparam int ADDR_W = 2;
    localparam logic [ADDR_W-1:0] A_LOW  = 2'd0;
    localparam logic [ADDR_W-1:0] A_HIGH = 2'd1;
    localparam logic [ADDR_W-1:0] A_CTRL = 2'd2;
    localparam int CB_LEFT = 0;
    localparam int CB_IE   = 1;
    localparam int CB_FLAG = 2;
endpackage

// File: rtl/adc_rr_format.sv
module adc_rr_format #(
    parameter int RES_W = 10,
    parameter int BUS_W = 8
) (
    input  logic [RES_W-1:0] res_i,
    input  logic             left_i,
    output logic [BUS_W-1:0] low_o,
    output logic [BUS_W-1:0] high_o
);
    localparam int EXTRA = RES_W - BUS_W;
    localparam int PAD   = BUS_W - EXTRA;

    logic [BUS_W-1:0] r_low, r_high, l_low, l_high;

    always_comb begin
        r_low  = res_i[BUS_W-1:0];
        r_high = {{PAD{1'b0}}, res_i[RES_W-1:BUS_W]};
        l_high = res_i[RES_W-1:EXTRA];
        l_low  = {res_i[EXTRA-1:0], {PAD{1'b0}}};
        low_o  = left_i ? l_low  : r_low;
        high_o = left_i ? l_high : r_high;
    end
endmodule

// File: rtl/adc_rr_irq.sv
module adc_rr_irq (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    input  logic en_i,
    output logic flag_o,
    output logic irq_o
);
    logic flag_d, flag_q;

    always_comb begin
        flag_d = flag_q;
        if (clr_i) flag_d = 1'b0;
        if (set_i) flag_d = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) flag_q <= 1'b0;
        else     flag_q <= flag_d;
    end

    assign flag_o = flag_q;
    assign irq_o  = flag_q & en_i;
endmodule

// File: rtl/adc_result_regs.sv
module adc_result_regs
    import adc_rr_pkg::*;
#(
    parameter int RES_W = 10,
    parameter int BUS_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              conv_done_i,
    input  logic [RES_W-1:0]  conv_data_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic              bus_rd_i,
    input  logic              bus_wr_i,
    input  logic [BUS_W-1:0]  bus_wdata_i,
    output logic [BUS_W-1:0]  bus_rdata_o,
    output logic              irq_o
);
    typedef struct packed {
        logic [RES_W-1:0] res;
        logic             lock;
        logic             left;
        logic             ie;
    } st_t;

    st_t st_d, st_q;
    logic rd_low, rd_high, wr_ctrl, take, flag;
    logic [BUS_W-1:0] lo_fmt, hi_fmt, ctrl_byte;
    logic unused_wdata;

    assign unused_wdata = ^bus_wdata_i[BUS_W-1:CB_FLAG+1];

    always_comb begin
        rd_low  = bus_rd_i && (bus_addr_i == A_LOW);
        rd_high = bus_rd_i && (bus_addr_i == A_HIGH);
        wr_ctrl = bus_wr_i && (bus_addr_i == A_CTRL);
        take    = conv_done_i && !st_q.lock && !rd_low;

        st_d = st_q;
        if (take) st_d.res = conv_data_i;
        if (wr_ctrl) begin
            st_d.left = bus_wdata_i[CB_LEFT];
            st_d.ie   = bus_wdata_i[CB_IE];
        end
        if (rd_low)       st_d.lock = 1'b1;
        else if (rd_high) st_d.lock = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    adc_rr_format #(.RES_W(RES_W), .BUS_W(BUS_W)) u_fmt (
        .res_i  (st_q.res),
        .left_i (st_q.left),
        .low_o  (lo_fmt),
        .high_o (hi_fmt)
    );

    adc_rr_irq u_irq (
        .clk    (clk),
        .rst    (rst),
        .set_i  (conv_done_i),
        .clr_i  (wr_ctrl && bus_wdata_i[CB_FLAG]),
        .en_i   (st_q.ie),
        .flag_o (flag),
        .irq_o  (irq_o)
    );

    always_comb begin
        ctrl_byte          = '0;
        ctrl_byte[CB_LEFT] = st_q.left;
        ctrl_byte[CB_IE]   = st_q.ie;
        ctrl_byte[CB_FLAG] = flag;
        case (bus_addr_i)
            A_LOW:   bus_rdata_o = lo_fmt;
            A_HIGH:  bus_rdata_o = hi_fmt;
            A_CTRL:  bus_rdata_o = ctrl_byte;
            default: bus_rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/adc_rr_checker.sv
module adc_rr_checker #(
    parameter int RES_W = 10,
    parameter int BUS_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             conv_done_i,
    input logic             bus_rd_i,
    input logic [1:0]       bus_addr_i,
    input logic             irq_o,
    input logic [RES_W-1:0] res_q,
    input logic             lock_q,
    input logic             ie_q,
    input logic             flag_q,
    input logic             left_q,
    input logic [BUS_W-1:0] hi_fmt
);
    p_reset_clears_r1: assert property (@(posedge clk)
        rst |=> (res_q == '0 && !lock_q && !flag_q && !ie_q && !left_q));

    p_low_read_freezes_r5: assert property (@(posedge clk) disable iff (rst)
        (bus_rd_i && bus_addr_i == 2'd0) |=> lock_q);

    p_frozen_value_held_r5: assert property (@(posedge clk) disable iff (rst)
        lock_q |=> $stable(res_q));

    p_high_read_releases_r6: assert property (@(posedge clk) disable iff (rst)
        (bus_rd_i && bus_addr_i == 2'd1) |=> !lock_q);

    p_done_sets_flag_r7: assert property (@(posedge clk) disable iff (rst)
        conv_done_i |=> flag_q);

    p_irq_needs_enable_r7: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> (ie_q && flag_q));

    p_right_pad_zero_r3: assert property (@(posedge clk) disable iff (rst)
        !left_q |-> (hi_fmt[BUS_W-1:RES_W-BUS_W] == '0));
endmodule

bind adc_result_regs adc_rr_checker #(.RES_W(RES_W), .BUS_W(BUS_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .conv_done_i (conv_done_i),
    .bus_rd_i    (bus_rd_i),
    .bus_addr_i  (bus_addr_i),
    .irq_o       (irq_o),
    .res_q       (st_q.res),
    .lock_q      (st_q.lock),
    .ie_q        (st_q.ie),
    .flag_q      (flag),
    .left_q      (st_q.left),
    .hi_fmt      (hi_fmt)
);

// File: tb/adc_result_regs_bench.sv
module adc_result_regs_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       conv_done_i = 1'b0;
    logic [9:0] conv_data_i = '0;
    logic [1:0] bus_addr_i = '0;
    logic       bus_rd_i = 1'b0;
    logic       bus_wr_i = 1'b0;
    logic [7:0] bus_wdata_i = '0;
    logic [7:0] bus_rdata_o;
    logic       irq_o;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;

    int m_res = 0, m_lock = 0, m_left = 0, m_ie = 0, m_flag = 0;

    always #5 clk = ~clk;

    adc_result_regs u_adc_result_regs (
        .clk(clk), .rst(rst), .conv_done_i(conv_done_i), .conv_data_i(conv_data_i),
        .bus_addr_i(bus_addr_i), .bus_rd_i(bus_rd_i), .bus_wr_i(bus_wr_i),
        .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o), .irq_o(irq_o)
    );

    function automatic int exp_rd(int a);
        case (a)
            0: return m_left ? ((m_res % 4) * 64) : (m_res % 256);
            1: return m_left ? (m_res / 4) : (m_res / 256);
            2: return m_left + 2 * m_ie + 4 * m_flag;
            default: return 0;
        endcase
    endfunction

    task automatic check(string tag, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic peek(string tag);
        @(negedge clk);
        bus_rd_i = 0; bus_wr_i = 0; conv_done_i = 0;
        for (int a = 0; a < 4; a++) begin
            bus_addr_i = 2'(a);
            #1 check(tag, int'(bus_rdata_o), exp_rd(a));
        end
        check(tag, int'(irq_o), m_flag & m_ie);
    endtask

    task automatic step(string tag, bit rd, bit wr, int addr, int wd, bit dn, int cv);
        bit lo_rd, hi_rd;
        @(negedge clk);
        bus_rd_i = rd; bus_wr_i = wr; bus_addr_i = 2'(addr);
        bus_wdata_i = 8'(wd); conv_done_i = dn; conv_data_i = 10'(cv);
        #1 check(tag, int'(bus_rdata_o), exp_rd(addr));
        check(tag, int'(irq_o), m_flag & m_ie);
        @(posedge clk);
        lo_rd = rd && addr == 0;
        hi_rd = rd && addr == 1;
        if (dn && m_lock == 0 && !lo_rd) m_res = cv;
        if (dn) m_flag = 1;
        else if (wr && addr == 2 && wd[2]) m_flag = 0;
        if (wr && addr == 2) begin m_left = wd[0]; m_ie = wd[1]; end
        if (lo_rd) m_lock = 1;
        else if (hi_rd) m_lock = 0;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 0;
        peek("R1 reset state");
        step("R9 enable irq", 0, 1, 2, 8'h02, 0, 0);
        step("R10 capture", 0, 0, 0, 0, 1, 10'h2A5);
        peek("R3 right aligned");
        peek("R7 flag and irq");
        step("R9 set left", 0, 1, 2, 8'h03, 0, 0);
        peek("R4 left aligned");
        step("R8 clear flag", 0, 1, 2, 8'h06, 0, 0);
        peek("R8 flag cleared");
        step("R8 set wins", 0, 1, 2, 8'h06, 1, 10'h0C3);
        peek("R8 set beats clear");
        step("R8 clear again", 0, 1, 2, 8'h06, 0, 0);
        step("R5 low read", 1, 0, 0, 0, 0, 0);
        step("R5 done while frozen", 0, 0, 0, 0, 1, 10'h155);
        peek("R5 value held, R7 flag set");
        step("R6 high read with done", 1, 0, 1, 0, 1, 10'h3AA);
        step("R6 done after release", 0, 0, 0, 0, 1, 10'h0F0);
        peek("R6 captured after release");
        step("R5 low read with done", 1, 0, 0, 0, 1, 10'h3FF);
        peek("R5 same cycle drop");
        step("R6 high read release", 1, 0, 1, 0, 0, 0);
        step("R9 left mode", 0, 1, 2, 8'h03, 0, 0);
        step("R6 high only read", 1, 0, 1, 0, 0, 0);
        step("R6 done after high only", 0, 0, 0, 0, 1, 10'h3C3);
        peek("R6 no freeze from high read");
        step("R7 disable irq", 0, 1, 2, 8'h01, 0, 0);
        peek("R7 irq masked");
        step("R9 back to right", 0, 1, 2, 8'h00, 0, 0);
        peek("R9 reformat at once");
        step("R1 reset again", 0, 0, 0, 0, 0, 0);
        @(negedge clk) rst = 1;
        @(negedge clk) rst = 0;
        m_res = 0; m_lock = 0; m_left = 0; m_ie = 0; m_flag = 0;
        peek("R1 after second reset");
        step("R2 addr3 read", 0, 0, 3, 0, 0, 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule